// File: doc/BRIEF.md
# Stride Gray Address Link

This block carries instruction fetch addresses across a heavily loaded on-chip bus in a form that makes consecutive fetches cheap to transmit. Instruction fetch walks through memory one word at a time, so most addresses that a core issues are the previous address plus the word size in bytes. The block leaves the byte-offset bits below the word size in plain binary. It Gray-codes only the word index above them. As a result, a step of one word changes exactly one bus line. A plain binary bus can change many lines on such a step, for example at a carry across a power-of-two boundary.

The transmit side has two kinds of update. When the core reports a sequential step, the next bus word is computed directly in the Gray domain from the current bus word, without converting back to binary. When the core reports any other address, such as a branch target, that address is re-encoded in the same cycle. Neither kind costs an extra cycle. A receive-side decoder returns the binary byte address from the bus word. A pair of line-change meters reports, for every update, how many lines the coded bus changed and how many lines a plain binary bus would have changed. Power studies use this pair to compare the two buses.

The word size in bytes is a parameter. Its intended values are 4 and 8.

Top module: `stride_gray_link`

## Requirements
- R1: While reset is asserted and until the first accepted address, `bus_word`, `rx_addr`, `gray_flips` and `bin_flips` read zero, and `bus_valid` reads 0.
- R2: One cycle after `in_valid`=1 with `in_seq`=0, `bus_word` holds the encoding of `in_addr`. Bits below log2(STRIDE_BYTES) are copied unchanged. In the field u = addr >> log2(STRIDE_BYTES), each bit i is u[i] XOR u[i+1], and the top bit is copied.
- R3: `rx_addr` always equals the binary byte address whose encoding `bus_word` carries, in the same cycle, with no added delay.
- R4: One cycle after `in_valid`=1 with `in_seq`=1, `bus_word` equals the encoding of (previous address + STRIDE_BYTES) modulo 2^ADDR_W. `in_addr` has no effect on that cycle.
- R5: Every sequential step changes exactly one line of `bus_word`, including the step that wraps from the highest word address to address zero.
- R6: With `in_valid`=0, `bus_word` keeps its value on the next cycle.
- R7: `gray_flips` reports, in the same cycle that `bus_word` takes a new value, how many lines of `bus_word` changed on that update. The count is 0 after an idle cycle.
- R8: `bin_flips` reports, aligned with `gray_flips`, how many lines a plain binary address bus carrying the same address sequence would have changed.
- R9: `bus_valid` equals `in_valid` delayed by one cycle.
- R10: With STRIDE_BYTES=8, the three low bits pass through unchanged, and each sequential step of 8 bytes changes exactly one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An address update is offered this cycle |
| in_seq | input | 1 | 1: the update is a step of one word from the last address; 0: take `in_addr` |
| in_addr | input | ADDR_W | Binary byte address, used when `in_seq`=0 |
| bus_word | output | ADDR_W | Encoded bus lines, registered |
| bus_valid | output | 1 | `in_valid` delayed by one cycle |
| rx_addr | output | ADDR_W | Binary address decoded from `bus_word` |
| gray_flips | output | clog2(ADDR_W+1) | Lines of `bus_word` changed on the latest update |
| bin_flips | output | clog2(ADDR_W+1) | Lines a binary bus would have changed on the latest update |

## Verification
A corrupted bus register or a faulty Gray step shows up at `rx_addr` on the very next cycle: the decoded address no longer equals the bench's binary model, which advances by the stride on each sequential step. A step that lands on the wrong code usually changes zero lines or more than one line, so `gray_flips` also differs from 1 in that same cycle. An error in the binary shadow register appears only on `bin_flips`, but it remains visible at every later update because the shadow keeps drifting from the model. The wrap from the last word address to zero and arbitrary low offset bits during sequential runs are driven on purpose, because these are where a step computation most likely goes wrong.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

  // Kind of update applied to the bus register in a cycle.
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_JUMP = 2'd1,
    UPD_STEP = 2'd2
  } upd_e;

  function automatic upd_e classify(logic valid, logic seq);
    if (!valid) return UPD_HOLD;
    return seq ? UPD_STEP : UPD_JUMP;
  endfunction

endpackage

// File: rtl/sgl_encoder.sv
module sgl_encoder import sgl_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int SH     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  upd_e              kind,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [ADDR_W-1:0] bus_q,
  output logic [ADDR_W-1:0] bus_d
);

  localparam int UW = ADDR_W - SH;

  // Word index to reflected code.
  function automatic logic [UW-1:0] to_gray(logic [UW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // Next code in the reflected sequence, computed on the code itself.
  // Even parity: flip bit 0. Odd parity: flip the bit above the lowest one;
  // when that lowest one is the top bit, flip the top bit (wrap to zero).
  function automatic logic [UW-1:0] gray_step(logic [UW-1:0] g);
    logic [UW-1:0] n;
    int            p;
    n = g;
    p = UW - 1;
    if ((^g) == 1'b0) begin
      n[0] = ~n[0];
    end else begin
      for (int i = UW - 1; i >= 0; i--) begin
        if (g[i]) p = i;
      end
      if (p < UW - 1) n[p+1] = ~n[p+1];
      else            n[UW-1] = ~n[UW-1];
    end
    return n;
  endfunction

  logic [UW-1:0] jump_hi;
  logic [UW-1:0] step_hi;

  assign jump_hi = to_gray(in_addr[ADDR_W-1:SH]);
  assign step_hi = gray_step(bus_q[ADDR_W-1:SH]);

  always_comb begin
    unique case (kind)
      UPD_JUMP: bus_d = {jump_hi, in_addr[SH-1:0]};
      UPD_STEP: bus_d = {step_hi, bus_q[SH-1:0]};
      default:  bus_d = bus_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_q <= '0;
    else        bus_q <= bus_d;
  end

endmodule

// File: rtl/sgl_decoder.sv
module sgl_decoder #(
  parameter int ADDR_W = 32,
  parameter int SH     = 2
) (
  input  logic [ADDR_W-1:0] bus_word,
  output logic [ADDR_W-1:0] rx_addr
);

  logic [ADDR_W-1:0] chain;

  // Prefix XOR from the top bit down to the first coded bit.
  assign chain[ADDR_W-1] = bus_word[ADDR_W-1];
  for (genvar i = ADDR_W - 2; i >= SH; i--) begin : g_chain
    assign chain[i] = chain[i+1] ^ bus_word[i];
  end
  // Byte offset bits travel uncoded.
  assign chain[SH-1:0] = bus_word[SH-1:0];

  assign rx_addr = chain;

endmodule

// File: rtl/sgl_flip_meter.sv
module sgl_flip_meter import sgl_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int SH     = 2,
  parameter int CW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  upd_e              kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ADDR_W-1:0] bus_q,
  input  logic [ADDR_W-1:0] bus_d,
  output logic [CW-1:0]     gray_flips,
  output logic [CW-1:0]     bin_flips
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << SH;

  function automatic logic [CW-1:0] ones(logic [ADDR_W-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < ADDR_W; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  // Shadow of the address as a plain binary bus would carry it.
  logic [ADDR_W-1:0] bin_q;
  logic [ADDR_W-1:0] bin_d;

  always_comb begin
    unique case (kind)
      UPD_JUMP: bin_d = in_addr;
      UPD_STEP: bin_d = bin_q + STEP;
      default:  bin_d = bin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q      <= '0;
      gray_flips <= '0;
      bin_flips  <= '0;
    end else begin
      bin_q      <= bin_d;
      gray_flips <= ones(bus_d ^ bus_q);
      bin_flips  <= ones(bin_d ^ bin_q);
    end
  end

endmodule

// File: rtl/stride_gray_link.sv
module stride_gray_link import sgl_pkg::*; #(
  parameter int ADDR_W       = 32,
  parameter int STRIDE_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_seq,
  input  logic [ADDR_W-1:0]            in_addr,
  output logic [ADDR_W-1:0]            bus_word,
  output logic                         bus_valid,
  output logic [ADDR_W-1:0]            rx_addr,
  output logic [$clog2(ADDR_W+1)-1:0]  gray_flips,
  output logic [$clog2(ADDR_W+1)-1:0]  bin_flips
);

  localparam int SH = $clog2(STRIDE_BYTES);
  localparam int CW = $clog2(ADDR_W + 1);

  // Named events for the checker.
  upd_e              kind;
  logic              step_evt;
  logic              jump_evt;
  logic [ADDR_W-1:0] bus_next;

  assign kind     = classify(in_valid, in_seq);
  assign step_evt = (kind == UPD_STEP);
  assign jump_evt = (kind == UPD_JUMP);

  sgl_encoder #(.ADDR_W(ADDR_W), .SH(SH)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .in_addr (in_addr),
    .bus_q   (bus_word),
    .bus_d   (bus_next)
  );

  sgl_decoder #(.ADDR_W(ADDR_W), .SH(SH)) u_dec (
    .bus_word (bus_word),
    .rx_addr  (rx_addr)
  );

  sgl_flip_meter #(.ADDR_W(ADDR_W), .SH(SH), .CW(CW)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .in_addr    (in_addr),
    .bus_q      (bus_word),
    .bus_d      (bus_next),
    .gray_flips (gray_flips),
    .bin_flips  (bin_flips)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_valid <= 1'b0;
    else        bus_valid <= in_valid;
  end

endmodule

// File: rtl/sgl_chk.sv
module sgl_chk #(
  parameter int ADDR_W = 32,
  parameter int SH     = 2,
  parameter int CW     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_seq,
  input logic [ADDR_W-1:0] in_addr,
  input logic [ADDR_W-1:0] bus_word,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] rx_addr,
  input logic [CW-1:0]     gray_flips,
  input logic [CW-1:0]     bin_flips,
  input logic              step_evt,
  input logic              jump_evt
);

  // R5
  one_line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> $countones(bus_word ^ $past(bus_word)) == 1);

  // R2
  low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_evt |=> bus_word[SH-1:0] == $past(in_addr[SH-1:0]));

  // R3
  jump_round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_seq) |=> rx_addr == $past(in_addr));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(bus_word) && gray_flips == '0 && bin_flips == '0);

  // R7
  flip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(gray_flips) == $countones(bus_word ^ $past(bus_word)));

  // R9
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bus_valid == $past(in_valid));

  // R8
  bin_moves_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> bin_flips != '0);

endmodule

bind stride_gray_link sgl_chk #(.ADDR_W(ADDR_W), .SH(SH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_seq     (in_seq),
  .in_addr    (in_addr),
  .bus_word   (bus_word),
  .bus_valid  (bus_valid),
  .rx_addr    (rx_addr),
  .gray_flips (gray_flips),
  .bin_flips  (bin_flips),
  .step_evt   (step_evt),
  .jump_evt   (jump_evt)
);

// File: tb/test_stride_gray_link.sv
module test_stride_gray_link;

  localparam int CLK_P = 10;
  localparam int AW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_seq = 1'b0;
  logic [AW-1:0] in_addr = '0;

  logic [AW-1:0] bus4, rx4, bus8, rx8;
  logic          bv4, bv8;
  logic [5:0]    gf4, bf4, gf8, bf8;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_P/2) clk = ~clk;

  stride_gray_link #(.ADDR_W(AW), .STRIDE_BYTES(4)) i_stride_gray_link (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_seq(in_seq),
    .in_addr(in_addr), .bus_word(bus4), .bus_valid(bv4), .rx_addr(rx4),
    .gray_flips(gf4), .bin_flips(bf4)
  );

  stride_gray_link #(.ADDR_W(AW), .STRIDE_BYTES(8)) i_stride_gray_link_s8 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_seq(in_seq),
    .in_addr(in_addr), .bus_word(bus8), .bus_valid(bv8), .rx_addr(rx8),
    .gray_flips(gf8), .bin_flips(bf8)
  );

  // Reference model: binary addresses held per stride.
  logic [AW-1:0] m4 = '0;
  logic [AW-1:0] m8 = '0;

  // Code of a byte address: offset bits kept, each word-index bit XORed with its upper neighbour.
  function automatic logic [AW-1:0] ref_code(logic [AW-1:0] a, int sh);
    logic [AW-1:0] r;
    r = a;
    for (int i = sh; i < AW - 1; i++) r[i] = a[i] ^ a[i+1];
    return r;
  endfunction

  function automatic int popc(logic [AW-1:0] v);
    int n;
    n = 0;
    foreach (v[i]) if (v[i]) n++;
    return n;
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge; check at the next falling edge.
  task automatic cyc(logic v, logic s, logic [AW-1:0] a);
    logic [AW-1:0] o4, o8;
    o4 = m4;
    o8 = m8;
    in_valid = v;
    in_seq   = s;
    in_addr  = a;
    if (v) begin
      m4 = s ? m4 + 32'd4 : a;
      m8 = s ? m8 + 32'd8 : a;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2/R4 bus_word", bus4, ref_code(m4, 2));
    chk("R3 rx_addr", rx4, m4);
    chk("R9 bus_valid", 32'(bv4), 32'(v));
    chk("R7 gray_flips", 32'(gf4), 32'(popc(ref_code(m4, 2) ^ ref_code(o4, 2))));
    chk("R8 bin_flips", 32'(bf4), 32'(popc(m4 ^ o4)));
    chk("R10 bus_word s8", bus8, ref_code(m8, 3));
    chk("R10 rx_addr s8", rx8, m8);
    chk("R10 gray_flips s8", 32'(gf8), 32'(popc(ref_code(m8, 3) ^ ref_code(o8, 3))));
    if (v && s) begin
      chk("R5 one line per step", 32'(popc(bus4 ^ ref_code(o4, 2))), 32'd1);
      chk("R10 one line per step s8", 32'(popc(bus8 ^ ref_code(o8, 3))), 32'd1);
    end
    if (!v) chk("R6 hold", bus4, ref_code(o4, 2));
  endtask

  initial begin
    #(CLK_P * 150000);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 bus_word", bus4, '0);
    chk("R1 rx_addr", rx4, '0);
    chk("R1 bus_valid", 32'(bv4), 32'd0);
    chk("R1 flips", 32'({gf4, bf4}), 32'd0);
    rst_n = 1'b1;
    chk("R1 after release", bus8, '0);

    // R2: plain jumps, including offset bits
    cyc(1'b1, 1'b0, 32'h0000_1000);
    cyc(1'b1, 1'b0, 32'h8000_0003);
    cyc(1'b1, 1'b0, 32'h0000_0000);
    // R4/R5: sequential run across carry boundaries, in_addr is junk
    for (int k = 0; k < 70; k++) cyc(1'b1, 1'b1, 32'hDEAD_BEEF);
    // R6: idle cycles
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 32'h1234_5678);
    // R5/R10: wrap at the top of the address space with offset bits set
    cyc(1'b1, 1'b0, 32'hFFFF_FFF5);
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b1, 32'h0);
    cyc(1'b1, 1'b0, 32'hFFFF_FFF8);
    for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, 32'hFFFF_FFFF);
    // R3: round trip on random jumps
    for (int k = 0; k < 200; k++) cyc(1'b1, 1'b0, $urandom);
    // mixed traffic
    for (int k = 0; k < 3000; k++)
      cyc(($urandom % 4) != 0, ($urandom % 3) != 0, $urandom);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule